// File: doc/BRIEF.md
# Parallel Non-Volatile Memory Host Controller

This block sits between a simple host request port and a byte-wide parallel non-volatile memory. The memory has an address bus, a data bus, active-low chip-enable, output-enable and write-enable strobes, and a ready/busy line. The host places an address, write data, a read/write select and a polling-mode select on its port, then pulses start. The controller runs the strobe sequence, returns read data and signals the end of the operation with a one-cycle done pulse. An error flag goes with that pulse when a write never completed.

Every analog timing minimum of the memory is a parameter counted in system clocks. Each one is the nanosecond figure divided by the clock period and rounded up. The list covers access time, read cycle time, output-enable setup and hold around the write strobe, address setup and hold, write pulse width, data setup and hold, the delay before busy asserts, and the bus float time after the memory stops driving.

After each write pulse the memory programs itself internally. The controller waits for that to finish in one of two ways: it watches the ready line, or it reads the same location over and over until the top data bit matches the written top bit. A cycle-count timeout bounds the wait in both modes. The data driver toward the memory is enabled only inside the write phases, and only once output-enable has been high for the float time.

Top module: `pnvm_host_ctrl`

## Requirements
- R1: While reset is asserted, chip-enable, output-enable and write-enable are all high, the data driver is off, and done and error are low.
- R2: A read holds chip-enable and output-enable low with write-enable high for exactly max(T_ACC, T_RC) cycles. Data is sampled in the last of those cycles. Done pulses exactly that many cycles after the start edge, and the read data output holds the sampled byte.
- R3: During a write, output-enable stays high throughout, and write-enable is low for exactly T_WP consecutive cycles with chip-enable low and the data driver on.
- R4: The address is stable on every cycle chip-enable is low. Driven write data is stable while the driver is on, and it is driven for at least T_DS cycles before write-enable rises.
- R5: The data driver is never on while output-enable is low. It turns on only after output-enable has been high for at least T_FLT cycles, which includes a write issued directly after a read.
- R6: In ready-pin mode (poll select = 0), the controller does not finish before the memory's internal write has ended and the ready line has returned high.
- R7: In polling mode (poll select = 1), the controller issues repeated reads separated by strobe-high gaps. It finishes only when data bit DW-1 equals bit DW-1 of the written byte, which is after the internal write has ended.
- R8: If completion is not seen within T_TMO cycles of the start of waiting, the controller raises error together with done, in either mode.
- R9: A start pulse while an operation is in progress is ignored: it causes no write, no extra done and no extra strobe activity.
- R10: Done is high for exactly one cycle per operation, and error is high only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_start | input | 1 | Start pulse, accepted only when idle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Byte address |
| host_wdata | input | DW | Byte to write |
| host_poll | input | 1 | Completion method: 1 = data polling, 0 = ready line |
| host_done | output | 1 | One-cycle end-of-operation pulse |
| host_err | output | 1 | Write completion timed out (valid with done) |
| host_rdata | output | DW | Byte returned by the last read |
| nv_addr | output | AW | Memory address bus |
| nv_dq_out | output | DW | Data toward memory |
| nv_dq_drive | output | 1 | Enable of the data driver toward memory |
| nv_dq_in | input | DW | Data from memory |
| nv_ce_n | output | 1 | Chip enable, active low |
| nv_oe_n | output | 1 | Output enable, active low |
| nv_we_n | output | 1 | Write enable, active low |
| nv_ready | input | 1 | Memory ready (high) / busy (low) |

## Verification
The embedded properties check the cycle-level rules on every clock. They cover bus contention and the float interval before driving, write-enable only under chip-enable with output-enable high, stability of the address and write data, and the done and error pulse shape. Other behaviours depend on a memory's response and can only be shown by the bench scenarios. These are exact read latency, correct data returned, finishing only after the internal write ends in each completion mode, exact write pulse width, discarding of a start issued while busy, and the timeout path. The bench sweeps every address of a small configuration in both modes against a behavioural memory model.

// File: rtl/pnvm_host_ctrl.sv
module pnvm_host_ctrl #(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int T_ACC = 10,
  parameter int T_RC  = 10,
  parameter int T_OES = 1,
  parameter int T_AS  = 1,
  parameter int T_WP  = 8,
  parameter int T_DS  = 3,
  parameter int T_DH  = 1,
  parameter int T_OEH = 1,
  parameter int T_AH  = 5,
  parameter int T_DB  = 4,
  parameter int T_FLT = 3,
  parameter int T_GAP = 1,
  parameter int T_TMO = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_start,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_poll,
  output logic          host_done,
  output logic          host_err,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] nv_addr,
  output logic [DW-1:0] nv_dq_out,
  output logic          nv_dq_drive,
  input  logic [DW-1:0] nv_dq_in,
  output logic          nv_ce_n,
  output logic          nv_oe_n,
  output logic          nv_we_n,
  input  logic          nv_ready
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_LEN  = mx(mx(T_ACC, T_RC), 1);
  localparam int SET_LEN = mx(mx(T_OES, T_AS), mx(T_DS - T_WP, 1));
  localparam int WP_LEN  = mx(T_WP, 1);
  localparam int HLD_LEN = mx(mx(T_DH, T_OEH), mx(T_AH - T_WP, 1));
  localparam int DB_LEN  = mx(T_DB, 1);
  localparam int GAP_LEN = mx(T_GAP, 1);
  localparam int TMO_LEN = mx(T_TMO, 1);
  localparam int LMAX    = mx(mx(mx(RD_LEN, SET_LEN), mx(WP_LEN, HLD_LEN)), mx(DB_LEN, GAP_LEN));
  localparam int CW      = $clog2(LMAX + 1) + 1;
  localparam int TW      = $clog2(TMO_LEN + 1) + 1;
  localparam int FW      = $clog2(T_FLT + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_TURN, S_SET, S_PUL, S_HLD, S_BDLY, S_RDY, S_PRD, S_PGAP
  } st_t;

  // strobe image {ce_n, oe_n, we_n, drive}
  function automatic logic [3:0] strb(input st_t s);
    case (s)
      S_RD, S_PRD:  return 4'b0010;
      S_TURN:       return 4'b0110;
      S_SET, S_HLD: return 4'b0111;
      S_PUL:        return 4'b0101;
      default:      return 4'b1110;
    endcase
  endfunction

  st_t           st, nxt;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic [FW-1:0] flt;
  logic [3:0]    strb_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          poll_q;
  logic          fin, ferr;
  int            len;

  assign {nv_ce_n, nv_oe_n, nv_we_n, nv_dq_drive} = strb_q;
  assign nv_addr   = addr_q;
  assign nv_dq_out = wdata_q;

  always_comb begin
    case (st)
      S_RD, S_PRD: len = RD_LEN;
      S_SET:       len = SET_LEN;
      S_PUL:       len = WP_LEN;
      S_HLD:       len = HLD_LEN;
      S_BDLY:      len = DB_LEN;
      S_PGAP:      len = GAP_LEN;
      default:     len = 1;
    endcase
  end

  wire last    = (cnt == CW'(len - 1));
  wire tmo_end = (tmo == TW'(TMO_LEN - 1));
  wire match   = (nv_dq_in[DW-1] == wdata_q[DW-1]);

  always_comb begin
    nxt  = st;
    fin  = 1'b0;
    ferr = 1'b0;
    case (st)
      S_IDLE: if (host_start) nxt = host_write ? S_TURN : S_RD;
      S_RD:   if (last) fin = 1'b1;
      S_TURN: if (flt >= FW'(T_FLT)) nxt = S_SET;
      S_SET:  if (last) nxt = S_PUL;
      S_PUL:  if (last) nxt = S_HLD;
      S_HLD:  if (last) nxt = S_BDLY;
      S_BDLY: if (last) nxt = poll_q ? S_PRD : S_RDY;
      S_RDY: begin
        if (nv_ready) fin = 1'b1;
        else if (tmo_end) begin fin = 1'b1; ferr = 1'b1; end
      end
      S_PRD: begin
        if (last && match) fin = 1'b1;
        else if (tmo_end) begin fin = 1'b1; ferr = 1'b1; end
        else if (last) nxt = S_PGAP;
      end
      S_PGAP: begin
        if (tmo_end) begin fin = 1'b1; ferr = 1'b1; end
        else if (last) nxt = S_PRD;
      end
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      tmo        <= '0;
      flt        <= FW'(T_FLT);
      strb_q     <= 4'b1110;
      addr_q     <= '0;
      wdata_q    <= '0;
      poll_q     <= 1'b0;
      host_done  <= 1'b0;
      host_err   <= 1'b0;
      host_rdata <= '0;
    end else begin
      st        <= nxt;
      cnt       <= (nxt != st) ? '0 : cnt + 1'b1;
      strb_q    <= strb(nxt);
      host_done <= fin;
      host_err  <= ferr;
      if (!strb_q[2])                flt <= '0;
      else if (flt < FW'(T_FLT))     flt <= flt + 1'b1;
      if (st == S_RDY || st == S_PRD || st == S_PGAP) tmo <= tmo + 1'b1;
      else                                             tmo <= '0;
      if (st == S_IDLE && host_start) begin
        addr_q <= host_addr;
        poll_q <= host_poll;
        if (host_write) wdata_q <= host_wdata;
      end
      if (st == S_RD && last) host_rdata <= nv_dq_in;
    end
  end

  // R5
  dq_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_dq_drive |-> (nv_oe_n && flt >= FW'(T_FLT)));

  // R3
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_we_n |-> (nv_oe_n && !nv_ce_n && nv_dq_drive));

  // R2
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_oe_n |-> (nv_we_n && !nv_ce_n && !nv_dq_drive));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_ce_n && $past(!nv_ce_n)) |-> $stable(nv_addr));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_dq_drive && $past(nv_dq_drive)) |-> $stable(nv_dq_out));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> host_done);

endmodule

// File: tb/pnvm_host_ctrl_tb.sv
module pnvm_host_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 8;
  localparam int T_ACC = 4, T_RC = 3, T_OES = 1, T_AS = 1, T_WP = 3, T_DS = 2;
  localparam int T_DH = 1, T_OEH = 1, T_AH = 4, T_DB = 2, T_FLT = 2, T_GAP = 1, T_TMO = 120;
  localparam int RD_EXP = (T_ACC > T_RC) ? T_ACC : T_RC;

  logic clk = 0, rst_n = 0;
  logic host_start = 0, host_write = 0, host_poll = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_done, host_err;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] nv_addr;
  logic [DW-1:0] nv_dq_out, nv_dq_in;
  logic nv_dq_drive, nv_ce_n, nv_oe_n, nv_we_n, nv_ready;

  pnvm_host_ctrl #(.AW(AW), .DW(DW), .T_ACC(T_ACC), .T_RC(T_RC), .T_OES(T_OES), .T_AS(T_AS),
    .T_WP(T_WP), .T_DS(T_DS), .T_DH(T_DH), .T_OEH(T_OEH), .T_AH(T_AH), .T_DB(T_DB),
    .T_FLT(T_FLT), .T_GAP(T_GAP), .T_TMO(T_TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_poll(host_poll),
    .host_done(host_done), .host_err(host_err), .host_rdata(host_rdata),
    .nv_addr(nv_addr), .nv_dq_out(nv_dq_out), .nv_dq_drive(nv_dq_drive), .nv_dq_in(nv_dq_in),
    .nv_ce_n(nv_ce_n), .nv_oe_n(nv_oe_n), .nv_we_n(nv_we_n), .nv_ready(nv_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory
  logic [DW-1:0] mem [16];
  int olc = 0, dly = 0, busy_rem = 0, wlat = 5, wr_count = 0;
  bit abort = 0;
  int we_lo = 0, drv_cnt = 0, ohc = 0;
  logic prev_ce = 1, prev_we = 1;
  logic [AW-1:0] prev_addr = '0;
  int mon_chk = 0, mon_err = 0;
  wire mbusy = (dly > 0) || (busy_rem > 0);
  assign nv_ready = !(dly == 0 && busy_rem > 0);
  assign nv_dq_in = (!nv_ce_n && !nv_oe_n && olc >= T_ACC)
                    ? (mbusy ? {~mem[nv_addr][7], mem[nv_addr][6:0]} : mem[nv_addr])
                    : ~mem[nv_addr];

  initial for (int i = 0; i < 16; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (!nv_ce_n && !nv_oe_n) olc <= olc + 1; else olc <= 0;
    // R4 address stable under chip enable
    if (rst_n && !nv_ce_n && !prev_ce && nv_addr != prev_addr) begin
      mon_err++; $display("FAIL R4 addr moved actual=%0h expected=%0h", nv_addr, prev_addr);
    end
    // R5 no contention, float time respected
    if (rst_n && nv_dq_drive && (!nv_oe_n || ohc < T_FLT)) begin
      mon_err++; $display("FAIL R5 drive with oe_n=%0b float=%0d expected>=%0d", nv_oe_n, ohc, T_FLT);
    end
    ohc <= nv_oe_n ? ohc + 1 : 0;
    we_lo   <= nv_we_n ? 0 : we_lo + 1;
    drv_cnt <= (nv_dq_drive && !nv_ce_n) ? drv_cnt + 1 : 0;
    if (abort) begin busy_rem <= 0; dly <= 0; end
    else if (!prev_we && nv_we_n) begin
      mon_chk++;
      // R3 exact pulse width; R4 data setup
      if (we_lo != T_WP) begin
        mon_err++; $display("FAIL R3 we width actual=%0d expected=%0d", we_lo, T_WP);
      end
      if (drv_cnt < T_DS) begin
        mon_err++; $display("FAIL R4 data setup actual=%0d expected>=%0d", drv_cnt, T_DS);
      end
      mem[nv_addr] <= nv_dq_out;
      wr_count <= wr_count + 1;
      dly <= T_DB; busy_rem <= wlat;
    end else if (dly > 0) dly <= dly - 1;
    else if (busy_rem > 0) busy_rem <= busy_rem - 1;
    prev_ce <= nv_ce_n; prev_we <= nv_we_n; prev_addr <= nv_addr;
  end

  int checks = 0, errs = 0, cyc = 0;
  bit wd = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) wd <= 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic op(input logic wr, input logic [3:0] a, input logic [7:0] d, input logic poll,
                    output logic [7:0] rd, output logic e, output int lat);
    @(negedge clk);
    host_write = wr; host_addr = a; host_wdata = d; host_poll = poll; host_start = 1;
    @(negedge clk);
    host_start = 0;
    lat = 0;
    while (!host_done && !wd) begin @(negedge clk); lat++; end
    rd = host_rdata; e = host_err;
  endtask

  initial begin
    logic [7:0] rd;
    logic e;
    int lat, wc;
    int dn;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nv_ce_n && nv_oe_n && nv_we_n, "R1 strobes", {nv_ce_n, nv_oe_n, nv_we_n}, 3'b111);
    chk(!nv_dq_drive && !host_done && !host_err, "R1 drive/done/err",
        {nv_dq_drive, host_done, host_err}, 0);
    rst_n = 1;

    // writes to every address, alternating completion mode
    for (int a = 0; a < 16; a++) begin
      logic [7:0] p;
      p = 8'((a * 37 + 5) & 8'hFF);
      wlat = 5 + a * 3;
      op(1, 4'(a), p, a[0], rd, e, lat);
      chk(!e, a[0] ? "R7 poll no error" : "R6 ready no error", e, 0);
      chk(!mbusy, a[0] ? "R7 done after internal write" : "R6 done after internal write", mbusy, 0);
      @(negedge clk);
      chk(!host_done, "R10 single done", host_done, 0);
    end

    // reads of every address
    for (int a = 0; a < 16; a++) begin
      op(0, 4'(a), 8'h00, 0, rd, e, lat);
      chk(rd == 8'((a * 37 + 5) & 8'hFF), "R2 read data", rd, (a * 37 + 5) & 8'hFF);
      chk(lat == RD_EXP, "R2 read latency", lat, RD_EXP);
      chk(!e, "R10 no error on read", e, 0);
    end

    // R5 write right after read
    wlat = 4;
    op(0, 4'd2, 8'h00, 0, rd, e, lat);
    op(1, 4'd2, 8'h7E, 1, rd, e, lat);
    op(0, 4'd2, 8'h00, 0, rd, e, lat);
    chk(rd == 8'h7E, "R5 back-to-back write data", rd, 8'h7E);

    // R8 timeout, ready mode then polling mode
    for (int m = 0; m < 2; m++) begin
      wlat = 100000;
      op(1, 4'd9, 8'hC3, m[0], rd, e, lat);
      chk(e == 1, "R8 timeout error", e, 1);
      chk(lat >= T_TMO && lat <= T_TMO + 40, "R8 timeout latency", lat, T_TMO);
      abort = 1; @(negedge clk); @(negedge clk); abort = 0;
    end

    // R9 start during a read is ignored
    wlat = 4;
    wc = wr_count;
    @(negedge clk);
    host_write = 0; host_addr = 4'd3; host_poll = 0; host_start = 1;
    @(negedge clk);
    host_write = 1; host_addr = 4'd5; host_wdata = 8'hAA; host_start = 1;
    @(negedge clk);
    host_start = 0;
    while (!host_done && !wd) @(negedge clk);
    dn = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (host_done || !nv_ce_n) dn++;
    end
    chk(wr_count == wc, "R9 no write from ignored start", wr_count, wc);
    chk(dn == 0, "R9 no extra activity", dn, 0);
    chk(mem[5] == 8'((5 * 37 + 5) & 8'hFF), "R9 memory unchanged", mem[5], (5 * 37 + 5) & 8'hFF);

    // monitor results (R3, R4, R5)
    chk(mon_chk == wr_count, "R3 pulses observed", mon_chk, wr_count);
    chk(mon_err == 0, "R3 R4 R5 monitor", mon_err, 0);
    errs += 0;
    if (wd) begin errs++; checks++; $display("FAIL watchdog actual=%0d expected=<150000", cyc); end
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule